// File: doc/BRIEF.md
# Counterflow Pipeline Flush Controller

This block steers recovery for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) whose stage outputs can report a late-arriving timing fault. When a stage flags a fault, the controller does not freeze the pipeline. It marks the faulty result as a bubble in the next stage and sends a flush token backward. The token moves one stage per cycle toward fetch. Every stage the token visits is discarded, and once the token reaches fetch, the program counter is redirected to the faulty instruction so that it runs again.

All recovery state is held in registers that move one position per cycle. No combinational path spans the pipeline. The surrounding datapath owns the valid bits. In any cycle where `flush[j]` is high, it discards both the instruction held in stage j and the instruction moving from stage j-1 into stage j. In any cycle where `bubble[k]` is high, it discards the instruction held in stage k+1. An instruction in write-back commits only when its slot is still valid. A panic input empties the whole pipeline in one step.

Stage index 0 is fetch and index 4 is write-back. Fault inputs exist only for stages 0 to 3, because a fault there is caught before write-back consumes the result. The PC bus carries stages 0 to 3, with stage k at bits `[k*32 +: 32]`.

Top module: `counterflow_flush_ctl`

## Requirements
- R1: While reset is applied, and for the cycles right after it, `bubble`, `flush`, `pc_restart` and `restart_pc` are all zero.
- R2: A fault on `stage_err[i]` with no recovery active raises `bubble[i]` (meaning stage i+1) for exactly the next cycle, and for that cycle only.
- R3: After an accepted fault at stage i in cycle t, `flush[i]` is high at t+1, `flush[i-1]` at t+2, and so on down to `flush[0]` at t+1+i. Outside a panic, at most one `flush` bit is high in any cycle.
- R4: `pc_restart` is high together with `flush[0]` in cycle t+1+i, for one cycle. `restart_pc` then equals the stage-i PC sampled in cycle t, and it holds that value until the next recovery.
- R5: A fault at a stage at or below the token's current position is ignored. It raises no bubble and changes neither `restart_pc` nor the token's schedule.
- R6: A fault above the token's position (an older instruction) replaces the token. A new token starts at the faulting stage, and the new restart PC is the PC of that stage.
- R7: When several stages fault in one cycle, the highest index (oldest instruction) wins, and only its bubble bit is raised.
- R8: `panic` in cycle t raises all five `flush` bits and `pc_restart` in cycle t+1 only. `restart_pc` becomes the PC of stage 3 (memory) at t, and any token in flight is cancelled. Faults in cycle t and in cycle t+1 are ignored.
- R9: With a datapath that honours `bubble` and `flush`, the committed PC sequence is 0, 4, 8, … with no gap and no repeat, for every fault and panic pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stage_err | input | 4 | Fault flags of stages 0 (fetch) to 3 (memory) |
| stage_pc | input | 128 | PCs of stages 0 to 3, stage k at bits [k*32 +: 32] |
| panic | input | 1 | Request to empty the whole pipeline |
| bubble | output | 4 | Bit k: the instruction now in stage k+1 is void |
| flush | output | 5 | Bit j: discard stage j and the instruction entering it |
| pc_restart | output | 1 | Fetch from `restart_pc` this cycle |
| restart_pc | output | 32 | Recovery fetch address |

## Verification
Assertions check the following on every cycle:
- the token advancing by one stage per cycle;
- a single flush bit outside a panic, and `pc_restart` only together with `flush[0]`;
- acceptance of a fault, with its bubble and captured PC;
- faults behind the token being ignored;
- the shape of the panic response.

The bench's scenarios show what no single property can. Its behavioural pipeline commits instructions in order across isolated, simultaneous, overlapping and panic-interrupted recoveries. The program-order commit stream is then compared against an error-free sequence.

// File: rtl/cf_flush_pkg.sv
`timescale 1ns/1ps
package cf_flush_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_FAULT = 2'd1,
    CAUSE_PANIC = 2'd2
  } cause_e;
endpackage

// File: rtl/cf_err_filter.sv
`timescale 1ns/1ps
// Accepts the oldest fault that is not already covered by a token in flight.
module cf_err_filter #(
  parameter int NERR = 4
) (
  input  logic [NERR-1:0] err,
  input  logic [NERR-1:0] tok,
  input  logic            pan_q,
  output logic [NERR-1:0] sel
);
  always_comb begin
    logic blk;
    logic hit;
    blk = pan_q;
    hit = 1'b0;
    sel = '0;
    for (int j = NERR-1; j >= 0; j--) begin
      blk = blk | tok[j];
      if (err[j] && !blk && !hit) begin
        sel[j] = 1'b1;
        hit    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cf_pc_pick.sv
`timescale 1ns/1ps
// AND-OR multiplexer selecting the PC of the accepted stage.
module cf_pc_pick #(
  parameter int NERR = 4,
  parameter int PCW  = 32
) (
  input  logic [NERR-1:0]     sel,
  input  logic [NERR*PCW-1:0] pcs,
  output logic [PCW-1:0]      pc_out
);
  logic [PCW-1:0] term [NERR];

  genvar g;
  generate
    for (g = 0; g < NERR; g++) begin : g_term
      assign term[g] = {PCW{sel[g]}} & pcs[g*PCW +: PCW];
    end
  endgenerate

  always_comb begin
    pc_out = '0;
    for (int j = 0; j < NERR; j++) pc_out = pc_out | term[j];
  end
endmodule

// File: rtl/cf_token_regs.sv
`timescale 1ns/1ps
// Token, bubble, panic and restart-PC registers with their next-state logic.
module cf_token_regs
  import cf_flush_pkg::*;
#(
  parameter int NERR = 4,
  parameter int PCW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            panic,
  input  logic [NERR-1:0] sel,
  input  logic [PCW-1:0]  sel_pc,
  input  logic [PCW-1:0]  mem_pc,
  output logic [NERR-1:0] tok_q,
  output logic [NERR-1:0] bub_q,
  output logic            pan_q,
  output logic [PCW-1:0]  rpc_q
);
  cause_e          cause;
  logic [NERR-1:0] tok_d;
  logic [NERR-1:0] bub_d;
  logic            pan_d;
  logic            rpc_en;
  logic [PCW-1:0]  rpc_d;

  always_comb begin
    if (panic)     cause = CAUSE_PANIC;
    else if (|sel) cause = CAUSE_FAULT;
    else           cause = CAUSE_NONE;
    case (cause)
      CAUSE_PANIC: begin
        tok_d = '0; bub_d = '0; pan_d = 1'b1; rpc_en = 1'b1; rpc_d = mem_pc;
      end
      CAUSE_FAULT: begin
        tok_d = sel; bub_d = sel; pan_d = 1'b0; rpc_en = 1'b1; rpc_d = sel_pc;
      end
      default: begin
        tok_d = tok_q >> 1; bub_d = '0; pan_d = 1'b0; rpc_en = 1'b0; rpc_d = rpc_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= '0;
      bub_q <= '0;
      pan_q <= 1'b0;
      rpc_q <= '0;
    end else begin
      tok_q <= tok_d;
      bub_q <= bub_d;
      pan_q <= pan_d;
      if (rpc_en) rpc_q <= rpc_d;
    end
  end

  // R7: the winning fault is the only one bubbled
  assert_bubble_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bub_q));
  // R3: a single token travels at a time
  assert_token_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_q));
endmodule

// File: rtl/counterflow_flush_ctl.sv
`timescale 1ns/1ps
module counterflow_flush_ctl #(
  parameter int NSTG = 5,
  parameter int PCW  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSTG-2:0]          stage_err,
  input  logic [(NSTG-1)*PCW-1:0]  stage_pc,
  input  logic                     panic,
  output logic [NSTG-2:0]          bubble,
  output logic [NSTG-1:0]          flush,
  output logic                     pc_restart,
  output logic [PCW-1:0]           restart_pc
);
  localparam int NERR  = NSTG - 1;
  localparam int MEMIX = NSTG - 2;

  logic [1:0]      rs_q;
  logic            rst_sync_n;
  logic [NERR-1:0] sel;
  logic [NERR-1:0] tok_q;
  logic [NERR-1:0] bub_q;
  logic            pan_q;
  logic [PCW-1:0]  sel_pc;
  logic [PCW-1:0]  rpc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  cf_err_filter #(.NERR(NERR)) u_filter (
    .err   (stage_err),
    .tok   (tok_q),
    .pan_q (pan_q),
    .sel   (sel)
  );

  cf_pc_pick #(.NERR(NERR), .PCW(PCW)) u_pick (
    .sel    (sel),
    .pcs    (stage_pc),
    .pc_out (sel_pc)
  );

  cf_token_regs #(.NERR(NERR), .PCW(PCW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .panic  (panic),
    .sel    (sel),
    .sel_pc (sel_pc),
    .mem_pc (stage_pc[MEMIX*PCW +: PCW]),
    .tok_q  (tok_q),
    .bub_q  (bub_q),
    .pan_q  (pan_q),
    .rpc_q  (rpc_q)
  );

  assign bubble           = bub_q;
  assign flush[NERR-1:0]  = tok_q | {NERR{pan_q}};
  assign flush[NSTG-1]    = pan_q;
  assign pc_restart       = tok_q[0] | pan_q;
  assign restart_pc       = rpc_q;

  // R4: redirect only together with a fetch flush
  assert_restart_flush_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_restart |-> flush[0]);
  // R3: one flush bit outside a panic
  assert_single_flush_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !flush[NSTG-1] |-> $onehot0(flush));
  // R8: panic empties everything next cycle
  assert_panic_all_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    panic |=> ((&flush) && pc_restart && (bubble == '0)));
  assert_panic_pc_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    panic |=> (restart_pc == $past(stage_pc[MEMIX*PCW +: PCW])));

  genvar g;
  generate
    for (g = 0; g < NERR; g++) begin : g_chk
      localparam logic [NERR-1:0] ABOVE = ~((NERR'(1) << (g + 1)) - NERR'(1));
      localparam logic [NSTG-1:0] ATUP  = ~((NSTG'(1) << g) - NSTG'(1));
      // R2 and R6: a fault not covered by a token at or above it is accepted
      assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (stage_err[g] && !panic && ((stage_err & ABOVE) == '0) && ((flush & ATUP) == '0))
        |=> ((bubble == (NERR'(1) << g)) && (flush == (NSTG'(1) << g))
             && (restart_pc == $past(stage_pc[g*PCW +: PCW]))));
      // R5: a fault behind the token leaves no trace
      assert_ignore_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        ((stage_err == (NERR'(1) << g)) && !panic && ((flush & ATUP) != '0))
        |=> ((bubble == '0) && $stable(restart_pc)));
      if (g >= 1) begin : g_walk
        // R3: token steps one stage toward fetch per cycle
        assert_token_walk_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
          (flush[g] && !flush[NSTG-1] && !panic && ((stage_err & ABOVE) == '0))
          |=> (flush == (NSTG'(1) << (g - 1))));
      end
    end
  endgenerate
endmodule

// File: tb/counterflow_flush_ctl_bench.sv
`timescale 1ns/1ps
module counterflow_flush_ctl_bench;
  logic         clk;
  logic         rst_n;
  logic [3:0]   err;
  logic [127:0] spc;
  logic         panic;
  logic [3:0]   bubble;
  logic [4:0]   flush;
  logic         pc_restart;
  logic [31:0]  restart_pc;

  counterflow_flush_ctl u_counterflow_flush_ctl (
    .clk(clk), .rst_n(rst_n), .stage_err(err), .stage_pc(spc), .panic(panic),
    .bubble(bubble), .flush(flush), .pc_restart(pc_restart), .restart_pc(restart_pc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int commits = 0;
  bit done = 0;

  logic        m_v  [0:4];
  logic [31:0] m_pc [0:4];
  logic [31:0] snap [0:4];
  logic [31:0] fetch_pc;
  logic [31:0] exp_pc;
  logic [3:0]  ob_bub;
  logic [4:0]  ob_fl;
  logic        ob_rs;
  logic [31:0] ob_rpc;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // One cycle: observe outputs, drive inputs, advance the pipeline model.
  task automatic tick(input logic [3:0] e, input logic p);
    @(negedge clk);
    ob_bub = bubble; ob_fl = flush; ob_rs = pc_restart; ob_rpc = restart_pc;
    for (int k = 0; k < 5; k++) snap[k] = m_pc[k];
    for (int k = 0; k < 4; k++) spc[k*32 +: 32] = m_pc[k];
    err = e;
    panic = p;
    if (m_v[4] && !ob_fl[4] && !ob_bub[3]) begin
      check(m_pc[4] == exp_pc, "R9 commit order", m_pc[4], exp_pc);
      exp_pc = m_pc[4] + 32'd4;
      commits++;
    end
    for (int j = 4; j >= 1; j--) begin
      logic kill;
      kill = ob_fl[j-1] | ob_fl[j];
      if (j >= 2) kill = kill | ob_bub[j-2];
      m_v[j]  = m_v[j-1] & ~kill;
      m_pc[j] = m_pc[j-1];
    end
    m_v[0]   = 1'b1;
    m_pc[0]  = ob_rs ? ob_rpc : fetch_pc;
    fetch_pc = m_pc[0] + 32'd4;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(4'b0, 1'b0);
  endtask

  task automatic expect_out(input string rq, input logic [3:0] b, input logic [4:0] f, input logic r);
    check(ob_bub == b, rq, 64'(ob_bub), 64'(b));
    check(ob_fl == f, rq, 64'(ob_fl), 64'(f));
    check(ob_rs == r, rq, 64'(ob_rs), 64'(r));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; err = '0; panic = 1'b0; spc = '0;
    for (int k = 0; k < 5; k++) begin m_v[k] = 1'b0; m_pc[k] = '0; end
    fetch_pc = '0; exp_pc = '0;
    repeat (3) @(negedge clk);
    check(bubble == 0 && flush == 0 && !pc_restart, "R1 reset outputs", {bubble, flush, pc_restart}, 0);
    check(restart_pc == 0, "R1 reset pc", restart_pc, 0);
    rst_n = 1'b1;
    idle(3);
    expect_out("R1 after release", 4'b0, 5'b0, 1'b0);
    idle(10);
  endtask

  task automatic t_single(input int i, input string rq);
    logic [31:0] p;
    tick(4'b1 << i, 1'b0);
    p = snap[i];
    tick(4'b0, 1'b0);
    expect_out({rq, " R2 bubble"}, 4'b1 << i, 5'b1 << i, i == 0);
    for (int s = i - 1; s >= 0; s--) begin
      tick(4'b0, 1'b0);
      expect_out({rq, " R3 walk"}, 4'b0, 5'b1 << s, s == 0);
    end
    check(ob_rpc == p, "R4 restart pc", ob_rpc, p);
    tick(4'b0, 1'b0);
    expect_out("R4 single pulse", 4'b0, 5'b0, 1'b0);
    check(ob_rpc == p, "R4 pc held", ob_rpc, p);
    idle(12);
  endtask

  task automatic t_simul();
    logic [31:0] p;
    tick(4'b0101, 1'b0);
    p = snap[2];
    tick(4'b0, 1'b0);
    expect_out("R7 oldest wins", 4'b0100, 5'b00100, 1'b0);
    idle(2);
    expect_out("R7 restart", 4'b0, 5'b00001, 1'b1);
    check(ob_rpc == p, "R7 restart pc", ob_rpc, p);
    idle(12);
  endtask

  task automatic t_ignore();
    logic [31:0] p;
    tick(4'b1000, 1'b0);
    p = snap[3];
    tick(4'b0010, 1'b0);          // token at 3, fault at 1 behind it
    expect_out("R5 token start", 4'b1000, 5'b01000, 1'b0);
    tick(4'b0100, 1'b0);          // token at 2, fault at same stage
    expect_out("R5 below ignored", 4'b0, 5'b00100, 1'b0);
    check(ob_rpc == p, "R5 pc unchanged", ob_rpc, p);
    tick(4'b0, 1'b0);
    expect_out("R5 equal ignored", 4'b0, 5'b00010, 1'b0);
    tick(4'b0, 1'b0);
    expect_out("R5 schedule kept", 4'b0, 5'b00001, 1'b1);
    check(ob_rpc == p, "R5 restart pc", ob_rpc, p);
    idle(12);
  endtask

  task automatic t_override();
    logic [31:0] p;
    tick(4'b0010, 1'b0);
    tick(4'b1000, 1'b0);          // older fault while token at 1
    p = snap[3];
    expect_out("R6 first token", 4'b0010, 5'b00010, 1'b0);
    tick(4'b0, 1'b0);
    expect_out("R6 new token", 4'b1000, 5'b01000, 1'b0);
    idle(3);
    expect_out("R6 restart", 4'b0, 5'b00001, 1'b1);
    check(ob_rpc == p, "R6 restart pc", ob_rpc, p);
    idle(12);
  endtask

  task automatic t_panic_quiet();
    logic [31:0] p;
    tick(4'b0100, 1'b1);
    p = snap[3];
    tick(4'b0100, 1'b0);          // fault in the cycle after panic
    expect_out("R8 all flushed", 4'b0, 5'b11111, 1'b1);
    check(ob_rpc == p, "R8 restart pc", ob_rpc, p);
    tick(4'b0, 1'b0);
    expect_out("R8 faults ignored", 4'b0, 5'b0, 1'b0);
    idle(12);
  endtask

  task automatic t_panic_flight();
    logic [31:0] p;
    tick(4'b0010, 1'b0);
    tick(4'b0, 1'b1);
    p = snap[3];
    expect_out("R8 token before panic", 4'b0010, 5'b00010, 1'b0);
    tick(4'b0, 1'b0);
    expect_out("R8 panic flush", 4'b0, 5'b11111, 1'b1);
    check(ob_rpc == p, "R8 panic pc", ob_rpc, p);
    tick(4'b0, 1'b0);
    expect_out("R8 token cancelled", 4'b0, 5'b0, 1'b0);
    idle(12);
  endtask

  initial begin
    t_reset();
    t_single(2, "R3 stage2");
    t_single(0, "R4 stage0");
    t_single(3, "R3 stage3");
    t_single(1, "R2 stage1");
    t_simul();
    t_ignore();
    t_override();
    t_panic_quiet();
    t_panic_flight();
    check(commits > 60, "R9 commit count", commits, 61);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", commits, 61);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule